// File: doc/BRIEF.md
# Tiled Video Scan-Out Engine

The engine produces 3-bit colour pixels for a 640x480 display from a tile map and tile patterns held in a byte-wide external SRAM. The screen is a grid of 8x8-pixel tiles, 80 across and 60 down. Each 16-bit map entry names a pattern and carries mirror bits. Each pattern holds 8 rows of 24 bits, so one tile takes 24 bytes. The map sits at the bottom of the SRAM. Patterns follow directly after the map.

Display timing comes from outside as pixel x/y counters plus an active flag, presented one pixel per core clock. One band is eight scanlines, matching one row of tiles. A read sequencer copies the map entries and all pattern rows of a band into one half of a two-bank on-chip store. A serializer meanwhile shifts pixels out of the other half. Every SRAM read holds its address and strobe for a parameterised number of cycles. The first band of each frame is loaded during vertical blanking. A sticky flag reports a band that was not ready when the display reached it.

Top module: `tile_scanout`

## Requirements
- R1: Pixel (x,y) in the active area is a 3-bit field of a 24-bit row word. Let t = 8-pixel column, p = x mod 8, r = y mod 8. The row word is built from three bytes at PAT + N*24 + r*3 + {0,1,2}, where PAT = TILES_X*TILES_Y*2 and N is the tile number. The byte at offset 0 is the most significant. Pixel p takes bits [23-3p : 21-3p]. Output is one clock after the inputs.
- R2: The map entry for tile column t in tile row b is read from addresses 2k (bits 15:8) and 2k+1 (bits 7:0), where k = b*TILES_X + t. N is bits 9:0. Bit 15 mirrors the tile left-right and bit 14 mirrors it top-bottom. Bits 13:10 are ignored.
- R3: With bit 15 set, pixel p of a tile row is taken from position 7-p.
- R4: With bit 14 set, display row r of the tile comes from pattern row 7-r.
- R5: When the active flag is low, pix_out is 0 one clock later.
- R6: While band b is on screen, band b+1 is loaded into the other bank, and band b displays correctly during that load.
- R7: Band 0 is loaded afresh during vertical blanking (y >= TILES_Y*8) of every frame, so map and pattern changes made before blanking appear in the next frame.
- R8: late_flag is set and stays set until reset when the display enters a band (active, x = 0, y mod 8 = 0) whose load has not finished. It stays low when every band is ready.
- R9: Every SRAM read keeps sram_rd high and sram_addr stable for WAIT_CYC cycles. One band costs TILES_X*26*WAIT_CYC strobe cycles.
- R10: While reset is low, pix_out is 0, sram_rd is 0 and late_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_x | input | XW | Horizontal pixel counter |
| pix_y | input | YW | Vertical line counter |
| pix_active | input | 1 | High inside the visible area |
| sram_rdata | input | 8 | SRAM read data |
| sram_addr | output | 15 | SRAM byte address |
| sram_rd | output | 1 | SRAM read strobe |
| pix_out | output | 3 | Pixel colour |
| late_flag | output | 1 | Sticky band-not-ready flag |

## Verification
The bench sweeps every pixel of several frames of a small grid. Each frame uses a different map and pattern seed, and all four mirror combinations appear. The corner cases are these:
- A swapped byte order would scramble colours.
- A mirror applied to the wrong axis would show up as a mismatch at the edge pixels.
- Writing into the bank on screen would corrupt a band during the next band's load.
- Skipping the per-frame reload of band 0 would show stale data after the seed changes.

The bench also starts a frame with no blanking, to force a late band. It checks that the flag sets, that reset clears it, and that it stays low afterwards. It counts strobe cycles per frame to catch a wrong hold length or a missed access.

// File: rtl/tile_pkg.sv
// Shared constants for the tiled scan-out engine.
// Assumes 8x8 tiles, 3-bit pixels and a 24-bit pattern row.
package tile_pkg;
    localparam int TILE_PX   = 8;
    localparam int ROW_BITS  = 24;
    localparam int PAT_BYTES = 24;
    localparam int STEPS     = 2 + PAT_BYTES;   // map bytes + pattern bytes per tile
endpackage

// File: rtl/tile_fetch_seq.sv
// SRAM read sequencer: loads one band (map entries + all pattern rows) into the
// band store. Each read holds address and strobe for WAIT_CYC cycles; data is
// taken on the last cycle of the access. Assumes combinational-valid read data
// by the end of the hold window.
module tile_fetch_seq
    import tile_pkg::*;
#(
    parameter int TILES_X  = 80,
    parameter int TILES_Y  = 60,
    parameter int WAIT_CYC = 3,
    parameter int AW       = 15,
    localparam int CW        = (TILES_X > 1) ? $clog2(TILES_X) : 1,
    localparam int BW        = $clog2(TILES_Y + 1),
    localparam int WW        = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1,
    localparam int MAP_BYTES = TILES_X * TILES_Y * 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] start_band,
    output logic          busy,
    output logic          ld_valid,
    output logic [BW-1:0] ld_band,
    output logic [AW-1:0] sram_addr,
    output logic          sram_rd,
    input  logic [7:0]    sram_rdata,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [CW-1:0] wr_col,
    output logic [2:0]    wr_row,
    output logic [23:0]   wr_word,
    output logic          fl_en,
    output logic          fl_hflip
);
    localparam int LAST_STEP = STEPS - 1;

    logic [BW-1:0] band;
    logic [CW-1:0] col;
    logic [4:0]    step;
    logic [WW-1:0] wcnt;
    logic [15:0]   entry;
    logic [15:0]   acc;
    logic          last_cyc;
    int            k_pat, prow, pbyte, rrow;
    logic [31:0]   a_full;

    assign last_cyc = busy && (wcnt == WW'(WAIT_CYC - 1));

    // Address of the current access: map entry bytes first, then pattern bytes.
    always_comb begin
        k_pat = int'(step) - 2;
        prow  = (k_pat < 0) ? 0 : k_pat / 3;
        pbyte = (k_pat < 0) ? 0 : k_pat % 3;
        rrow  = entry[14] ? (7 - prow) : prow;
        if (step < 5'd2)
            a_full = 32'((int'(band) * TILES_X + int'(col)) * 2 + int'(step));
        else
            a_full = 32'(MAP_BYTES + int'(entry[9:0]) * PAT_BYTES + rrow * 3 + pbyte);
    end

    assign sram_addr = a_full[AW-1:0];
    assign sram_rd   = busy;
    assign wr_bank   = band[0];
    assign wr_col    = col;
    assign wr_row    = prow[2:0];
    assign wr_word   = {acc, sram_rdata};
    assign wr_en     = last_cyc && (step >= 5'd2) && (pbyte == 2);
    assign fl_en     = last_cyc && (step == 5'd1);
    assign fl_hflip  = entry[15];

    // Band load state machine: steps through tiles, accesses and hold cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ld_valid <= 1'b0;
            ld_band  <= '0;
            band     <= '0;
            col      <= '0;
            step     <= '0;
            wcnt     <= '0;
            entry    <= '0;
            acc      <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                band <= start_band;
                col  <= '0;
                step <= '0;
                wcnt <= '0;
            end
        end else if (!last_cyc) begin
            wcnt <= wcnt + 1'b1;
        end else begin
            wcnt <= '0;
            if (step == 5'd0)      entry[15:8] <= sram_rdata;
            else if (step == 5'd1) entry[7:0]  <= sram_rdata;
            else                   acc         <= {acc[7:0], sram_rdata};
            if (step == 5'(LAST_STEP)) begin
                step <= '0;
                if (col == CW'(TILES_X - 1)) begin
                    busy     <= 1'b0;
                    ld_valid <= 1'b1;
                    ld_band  <= band;
                end else begin
                    col <= col + 1'b1;
                end
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // R9: address must not move inside one access window
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wcnt != '0) |-> $stable(sram_addr));

    // R1: tile column never leaves the grid during a load
    p_col_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(col) < TILES_X));

    // R7: finishing a load records the band that was loaded
    p_done_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ld_valid && ld_band == $past(band)));
endmodule

// File: rtl/tile_band_store.sv
// Ping-pong band store: two banks of TILES_X*8 pattern-row words plus one
// left-right mirror bit per tile. One write port (sequencer), one asynchronous
// read port (serializer). Reads outside the grid return zero.
module tile_band_store
    import tile_pkg::*;
#(
    parameter int TILES_X = 80,
    localparam int CW     = (TILES_X > 1) ? $clog2(TILES_X) : 1,
    localparam int XCW    = $clog2(TILES_X + 1) + 1,
    localparam int DEPTH  = 2 * TILES_X * TILE_PX
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                wr_bank,
    input  logic [CW-1:0]       wr_col,
    input  logic [2:0]          wr_row,
    input  logic [ROW_BITS-1:0] wr_word,
    input  logic                fl_en,
    input  logic                fl_hflip,
    input  logic                rd_bank,
    input  logic [XCW-1:0]      rd_col,
    input  logic [2:0]          rd_row,
    output logic [ROW_BITS-1:0] rd_word,
    output logic                rd_hflip
);
    logic [ROW_BITS-1:0] rows [DEPTH];
    logic                hf   [2 * TILES_X];
    int                  w_idx, r_idx;

    assign w_idx = (int'(wr_bank) * TILES_X + int'(wr_col)) * TILE_PX + int'(wr_row);
    assign r_idx = (int'(rd_bank) * TILES_X + int'(rd_col)) * TILE_PX + int'(rd_row);

    // Store pattern rows and mirror bits as the sequencer delivers them.
    always_ff @(posedge clk) begin
        if (wr_en) rows[w_idx] <= wr_word;
        if (fl_en) hf[int'(wr_bank) * TILES_X + int'(wr_col)] <= fl_hflip;
    end

    // Read the row and mirror bit of the tile under the beam.
    always_comb begin
        if (int'(rd_col) < TILES_X) begin
            rd_word  = rows[r_idx];
            rd_hflip = hf[int'(rd_bank) * TILES_X + int'(rd_col)];
        end else begin
            rd_word  = '0;
            rd_hflip = 1'b0;
        end
    end
endmodule

// File: rtl/tile_pixel_ser.sv
// Pixel serializer: picks the 3-bit pixel of a row word, applying left-right
// mirroring, and registers it. Output is forced to zero outside the active area.
module tile_pixel_ser
    import tile_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic [2:0]          px,
    input  logic [ROW_BITS-1:0] word,
    input  logic                hflip,
    output logic [2:0]          pix_out
);
    logic [2:0] pos;
    logic [2:0] pixel;

    assign pos   = hflip ? (3'd7 - px) : px;
    assign pixel = 3'(word >> (21 - 3 * int'(pos)));

    // Register the selected pixel, blanking outside the visible area.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_out <= '0;
        else if (active) pix_out <= pixel;
        else             pix_out <= '0;
    end
endmodule

// File: rtl/tile_scanout.sv
// Top of the tiled scan-out engine. Decides which band to load next from the
// beam position, raises the sticky late flag, and wires sequencer, band store
// and serializer. Assumes one pixel per clock and y >= TILES_Y*8 during
// vertical blanking.
module tile_scanout
    import tile_pkg::*;
#(
    parameter int TILES_X  = 80,
    parameter int TILES_Y  = 60,
    parameter int WAIT_CYC = 3,
    parameter int XW       = 10,
    parameter int YW       = 9,
    localparam int CW      = (TILES_X > 1) ? $clog2(TILES_X) : 1,
    localparam int XCW     = $clog2(TILES_X + 1) + 1,
    localparam int BW      = $clog2(TILES_Y + 1),
    localparam int H_PX    = TILES_Y * TILE_PX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    input  logic          pix_active,
    input  logic [7:0]    sram_rdata,
    output logic [14:0]   sram_addr,
    output logic          sram_rd,
    output logic [2:0]    pix_out,
    output logic          late_flag
);
    logic          busy, ld_valid, start;
    logic [BW-1:0] ld_band, start_band;
    logic          wr_en, wr_bank, fl_en, fl_hflip;
    logic [CW-1:0] wr_col;
    logic [2:0]    wr_row;
    logic [23:0]   wr_word, rd_word;
    logic          rd_hflip;
    logic          in_frame, band_entry, ready_now;
    int            disp_row, target;

    assign disp_row   = int'(pix_y) / TILE_PX;
    assign in_frame   = int'(pix_y) < H_PX;
    assign band_entry = pix_active && in_frame && (pix_y[2:0] == 3'd0) && (pix_x == '0);
    assign ready_now  = ld_valid && (int'(ld_band) == disp_row) && !busy;

    // Next band wanted: the one after the displayed band, or band 0 in blanking.
    always_comb begin
        target     = in_frame ? disp_row + 1 : 0;
        start      = !busy && (target < TILES_Y) &&
                     !(ld_valid && int'(ld_band) == target);
        start_band = BW'(target);
    end

    // Sticky flag: display reached a band whose load is not complete.
    always_ff @(posedge clk) begin
        if (!rst_n)                        late_flag <= 1'b0;
        else if (band_entry && !ready_now) late_flag <= 1'b1;
    end

    tile_fetch_seq #(.TILES_X(TILES_X), .TILES_Y(TILES_Y), .WAIT_CYC(WAIT_CYC), .AW(15)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_band(start_band),
        .busy(busy), .ld_valid(ld_valid), .ld_band(ld_band),
        .sram_addr(sram_addr), .sram_rd(sram_rd), .sram_rdata(sram_rdata),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .wr_row(wr_row),
        .wr_word(wr_word), .fl_en(fl_en), .fl_hflip(fl_hflip)
    );

    tile_band_store #(.TILES_X(TILES_X)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col),
        .wr_row(wr_row), .wr_word(wr_word), .fl_en(fl_en), .fl_hflip(fl_hflip),
        .rd_bank(disp_row[0]), .rd_col(XCW'(int'(pix_x) / TILE_PX)),
        .rd_row(pix_y[2:0]), .rd_word(rd_word), .rd_hflip(rd_hflip)
    );

    tile_pixel_ser u_ser (
        .clk(clk), .rst_n(rst_n), .active(pix_active), .px(pix_x[2:0]),
        .word(rd_word), .hflip(rd_hflip), .pix_out(pix_out)
    );

    // R6: a band load never writes into the bank being displayed
    p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_frame && !late_flag && !band_entry) |-> (wr_bank != disp_row[0]));

    // R8: once raised, the late flag stays up until reset
    p_late_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(late_flag) |-> late_flag);

    // R5: blank input gives a zero pixel on the next clock
    p_blank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active |=> (pix_out == 3'd0));
endmodule

// File: tb/tile_scanout_bench.sv
// Bench: 4x3 tile grid, two-cycle SRAM access, every pixel of several frames.
module tile_scanout_bench;
    localparam int TX = 4, TY = 3, WC = 2;
    localparam int W_PX = TX * 8, H_PX = TY * 8;
    localparam int LINE = W_PX + 8, VB = 8;
    localparam int MAPB = TX * TY * 2;
    localparam int RD_PER_FRAME = TY * TX * 26 * WC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [8:0]  pix_y = '0;
    logic        pix_active = 1'b0;
    logic [7:0]  sram_rdata;
    logic [14:0] sram_addr;
    logic        sram_rd;
    logic [2:0]  pix_out;
    logic        late_flag;

    int errors = 0, checks = 0, seed = 0, rdcnt = 0;
    logic [2:0] prev_exp = '0;
    bit         prev_chk = 1'b0;
    string      prev_tag = "R1";

    always #4 clk = ~clk;

    tile_scanout #(.TILES_X(TX), .TILES_Y(TY), .WAIT_CYC(WC)) u_tile_scanout (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .pix_active(pix_active), .sram_rdata(sram_rdata), .sram_addr(sram_addr),
        .sram_rd(sram_rd), .pix_out(pix_out), .late_flag(late_flag)
    );

    function automatic logic [15:0] map_entry(int k, int s);
        int t = (k * 7 + s * 3) % 40;
        int f = (k + s) % 4;
        return {f[1], f[0], 4'hA, 10'(t)};
    endfunction

    function automatic logic [7:0] mem_byte(int a, int s);
        logic [15:0] e;
        if (a < MAPB) begin
            e = map_entry(a / 2, s);
            return (a % 2 == 0) ? e[15:8] : e[7:0];
        end
        return 8'((a * 37 + s * 11 + 5) & 255);
    endfunction

    assign sram_rdata = mem_byte(int'(sram_addr), seed);

    function automatic logic [2:0] exp_pix(int x, int y, int s);
        logic [15:0] e = map_entry((y / 8) * TX + x / 8, s);
        int r = y % 8, p = x % 8, rr, pi, base;
        logic [23:0] w;
        rr   = e[14] ? 7 - r : r;
        pi   = e[15] ? 7 - p : p;
        base = MAPB + int'(e[9:0]) * 24 + rr * 3;
        w    = {mem_byte(base, s), mem_byte(base + 1, s), mem_byte(base + 2, s)};
        return 3'(w >> (21 - 3 * pi));
    endfunction

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Count strobe cycles for the access-length check.
    always @(posedge clk) if (rst_n && sram_rd) rdcnt++;

    // Drive one pixel position; check the previous position's output first.
    task automatic step_px(int x, int y, bit act, bit chk, int s);
        @(negedge clk);
        if (prev_chk) check(prev_tag, int'(pix_out), int'(prev_exp));
        pix_x = 10'(x); pix_y = 9'(y); pix_active = act;
        prev_chk = chk;
        if (!act) begin
            prev_exp = 3'd0; prev_tag = "R5";
        end else begin
            logic [15:0] e = map_entry((y / 8) * TX + x / 8, s);
            prev_exp = exp_pix(x, y, s);
            if (e[15])      prev_tag = "R3";
            else if (e[14]) prev_tag = "R4";
            else if (y >= 8) prev_tag = "R6";
            else            prev_tag = "R7 (R1,R2)";
        end
    endtask

    task automatic run_frame(int s, bit with_vb, bit chk);
        rdcnt = 0;
        if (with_vb) begin
            for (int l = 0; l < VB; l++)
                for (int x = 0; x < LINE; x++) begin
                    if (l == 0 && x == 0) seed = s;
                    step_px(x, H_PX + l, 1'b0, chk, s);
                end
        end else seed = s;
        for (int y = 0; y < H_PX; y++)
            for (int x = 0; x < LINE; x++)
                step_px(x, y, x < W_PX, chk, s);
        step_px(0, H_PX, 1'b0, chk, s);
        prev_chk = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 pix_out", int'(pix_out), 0);
        check("R10 sram_rd", int'(sram_rd), 0);
        check("R10 late_flag", int'(late_flag), 0);

        // Start straight into line 0 without blanking: band 0 is not ready.
        rst_n = 1'b1;
        run_frame(9, 1'b0, 1'b0);
        check("R8 late set", int'(late_flag), 1);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 late cleared", int'(late_flag), 0);
        check("R10 strobe low", int'(sram_rd), 0);
        pix_y = 9'(H_PX); pix_x = '0; pix_active = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int f = 0; f < 4; f++) begin
            run_frame(f * 5 + 1, 1'b1, 1'b1);
            check("R9 strobe cycles", rdcnt, RD_PER_FRAME);
            check("R8 no late", int'(late_flag), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule